// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block judges the destination address of an incoming Ethernet frame and says whether the station should keep the frame. The six destination bytes arrive one at a time, each qualified by a valid strobe, and the first of them is also marked with a start flag. While the bytes stream in, the block folds each one into a running CRC-32 and compares it against the station's own address. It also tracks whether every byte so far has been all ones.

The decision appears as a single-cycle pulse in the cycle after the last address byte. A group address (multicast) is judged by a 64-entry bit table indexed by six bits of the CRC. An individual address (unicast) must equal the programmed station address. The all-ones address can be let through by a broadcast enable, and a pass flag accepts everything. The table, the station address and the two flags sit in a small set of write-only configuration registers. All of them are zero after reset.

Top module: `mhf_addr_filter`

## Requirements
- R1: A write with `cfg_wr_en` high loads `cfg_wdata` into the register chosen by `cfg_sel` on the next clock edge. Code 0 selects table bits 31..0, code 1 selects table bits 63..32, code 2 selects station address bits 31..0, and code 3 selects station address bits 47..32 (taken from `cfg_wdata[15:0]`). Code 4 selects the control flags: bit 0 is broadcast enable and bit 1 is pass-all. Codes 5 to 7 change nothing.
- R2: An address begins with a byte that has both `rx_valid` and `rx_first` high. The next five bytes with `rx_valid` high complete it. Bytes with `rx_valid` high and `rx_first` low that arrive outside an address are ignored, and so are cycles with `rx_valid` low.
- R3: `dec_valid` is high for exactly one cycle: the cycle after the clock edge that took the sixth address byte. It never pulses at any other time.
- R4: `dec_hash_idx` equals bits 31..26 of a CRC over the six bytes in arrival order. The CRC is preset to all ones and uses polynomial 0x04C11DB7. Each byte is taken least significant bit first, and the register shifts left with feedback equal to the register's top bit XOR the data bit. No final inversion is applied.
- R5: When bit 0 of the first byte is 1 (a group address), the address is accepted exactly when table bit k is set, where k = `dec_hash_idx`. For k from 0 to 31 that is bit k of register code 0. For k from 32 to 63 it is bit k-32 of register code 1.
- R6: After reset the table is all zero, so every group address is rejected.
- R7: When bit 0 of the first byte is 0 (an individual address), the address is accepted only if byte i (i = 0 first) equals bits 8i+7..8i of the 48-bit station address formed from codes 3 and 2.
- R8: The all-ones address is accepted whenever broadcast enable is set, whatever the table holds. With broadcast enable clear, it is judged as a group address through the table.
- R9: With pass-all set, every address is accepted.
- R10: A byte with `rx_valid` and `rx_first` high that arrives part-way through an address drops the partial address and starts a new one.
- R11: `dec_accept` and `dec_hash_idx` keep their values from the last decision until the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register code |
| cfg_wdata | input | 32 | Configuration write data |
| rx_valid | input | 1 | Address byte valid |
| rx_first | input | 1 | Marks the first byte of an address |
| rx_byte | input | 8 | Address byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted (1) or rejected (0) |
| dec_hash_idx | output | 6 | Table index derived from the CRC |

## Verification
Some properties are checked on every cycle. The decision must be a lone pulse that follows an accepted byte. The decision outputs must hold steady between pulses, and pass-all must force acceptance. The byte counter must stay idle at zero and within the address length, and writes with unused codes must leave every register untouched. The bench's scenarios are the only way to show the rest. That covers the CRC index itself, the table bit selection in both halves, the byte-by-byte station comparison and the broadcast precedence. It also covers the reset-time rejection of group traffic, the restart on a fresh start flag and the silence on trailing frame bytes.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    typedef enum logic [2:0] {
        CFG_TBL_LO  = 3'd0,
        CFG_TBL_HI  = 3'd1,
        CFG_STN_LO  = 3'd2,
        CFG_STN_HI  = 3'd3,
        CFG_FLAGS   = 3'd4
    } cfg_sel_e;

    localparam int FLAG_BCAST_BIT = 0;
    localparam int FLAG_PASS_BIT  = 1;

    localparam logic [31:0] CRC32_POLY = 32'h04C11DB7;

endpackage

// File: rtl/mhf_cfg_regs.sv
module mhf_cfg_regs #(
    parameter int REG_W    = 32,
    parameter int STN_HI_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    tbl_lo,
    output logic [REG_W-1:0]    tbl_hi,
    output logic [REG_W-1:0]    stn_lo,
    output logic [STN_HI_W-1:0] stn_hi,
    output logic                bcast_en,
    output logic                pass_all
);
    import mhf_pkg::*;

    typedef struct packed {
        logic [REG_W-1:0]    tbl_lo;
        logic [REG_W-1:0]    tbl_hi;
        logic [REG_W-1:0]    stn_lo;
        logic [STN_HI_W-1:0] stn_hi;
        logic                bcast;
        logic                pass;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_sel)
                CFG_TBL_LO: cfg_d.tbl_lo = wr_data;
                CFG_TBL_HI: cfg_d.tbl_hi = wr_data;
                CFG_STN_LO: cfg_d.stn_lo = wr_data;
                CFG_STN_HI: cfg_d.stn_hi = wr_data[STN_HI_W-1:0];
                CFG_FLAGS: begin
                    cfg_d.bcast = wr_data[FLAG_BCAST_BIT];
                    cfg_d.pass  = wr_data[FLAG_PASS_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign tbl_lo   = cfg_q.tbl_lo;
    assign tbl_hi   = cfg_q.tbl_hi;
    assign stn_lo   = cfg_q.stn_lo;
    assign stn_hi   = cfg_q.stn_hi;
    assign bcast_en = cfg_q.bcast;
    assign pass_all = cfg_q.pass;

    // R1: unused selector codes leave every register as it was
    assert_bad_sel_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel > 3'd4) |=> $stable(cfg_q));

endmodule

// File: rtl/mhf_crc_byte.sv
module mhf_crc_byte #(
    parameter int               CRC_W  = 32,
    parameter logic [CRC_W-1:0] POLY   = mhf_pkg::CRC32_POLY,
    parameter int               DATA_W = 8
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] stage [DATA_W+1];

    assign stage[0] = crc_in;

    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
        logic fb;
        assign fb = stage[j][CRC_W-1] ^ data[j];
        assign stage[j+1] = {stage[j][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[DATA_W];

endmodule

// File: rtl/mhf_hash_lookup.sv
module mhf_hash_lookup #(
    parameter int IDX_W = 6,
    parameter int REG_W = 32
) (
    input  logic [REG_W-1:0] tbl_lo,
    input  logic [REG_W-1:0] tbl_hi,
    input  logic [IDX_W-1:0] idx,
    output logic             hit
);
    localparam int TABLE_W = 2 * REG_W;

    logic [TABLE_W-1:0] table_bits;

    assign table_bits = {tbl_hi, tbl_lo};
    assign hit        = table_bits[idx];

endmodule

// File: rtl/mhf_addr_filter.sv
module mhf_addr_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int REG_W      = 32,
    parameter int IDX_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [2:0]       cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             rx_valid,
    input  logic             rx_first,
    input  logic [7:0]       rx_byte,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic [IDX_W-1:0] dec_hash_idx
);
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = ADDR_BYTES * BYTE_W;
    localparam int STN_HI_W = ADDR_W - REG_W;
    localparam int CRC_W    = 32;
    localparam int CNT_W    = $clog2(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        logic             uc_eq;
        logic             all_ones;
        logic             grp;
        logic             dec_valid;
        logic             dec_accept;
        logic [IDX_W-1:0] dec_idx;
    } flt_t;

    flt_t flt_d, flt_q;

    logic [REG_W-1:0]    tbl_lo, tbl_hi, stn_lo;
    logic [STN_HI_W-1:0] stn_hi;
    logic                bcast_en, pass_all;

    mhf_cfg_regs #(.REG_W(REG_W), .STN_HI_W(STN_HI_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .tbl_lo   (tbl_lo),
        .tbl_hi   (tbl_hi),
        .stn_lo   (stn_lo),
        .stn_hi   (stn_hi),
        .bcast_en (bcast_en),
        .pass_all (pass_all)
    );

    // station address split into arrival-order bytes
    logic [ADDR_W-1:0] stn_vec;
    logic [BYTE_W-1:0] stn_byte [ADDR_BYTES];

    assign stn_vec = {stn_hi, stn_lo};
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_stn
        assign stn_byte[i] = stn_vec[i*BYTE_W +: BYTE_W];
    end

    logic             take, take_first;
    logic [CRC_W-1:0] crc_base, crc_nx;
    logic [IDX_W-1:0] idx_nx;
    logic             hit_nx;

    assign take_first = rx_valid && rx_first;
    assign take       = rx_valid && (rx_first || flt_q.busy);
    assign crc_base   = take_first ? '1 : flt_q.crc;

    mhf_crc_byte #(.CRC_W(CRC_W), .POLY(mhf_pkg::CRC32_POLY), .DATA_W(BYTE_W)) u_crc (
        .crc_in  (crc_base),
        .data    (rx_byte),
        .crc_out (crc_nx)
    );

    assign idx_nx = crc_nx[CRC_W-1 -: IDX_W];

    mhf_hash_lookup #(.IDX_W(IDX_W), .REG_W(REG_W)) u_lookup (
        .tbl_lo (tbl_lo),
        .tbl_hi (tbl_hi),
        .idx    (idx_nx),
        .hit    (hit_nx)
    );

    logic [CNT_W-1:0] cnt_cur;
    logic             uc_cur, ones_cur, grp_cur;

    always_comb begin
        flt_d           = flt_q;
        flt_d.dec_valid = 1'b0;

        cnt_cur  = take_first ? '0 : flt_q.cnt;
        uc_cur   = (take_first ? 1'b1 : flt_q.uc_eq) && (rx_byte == stn_byte[cnt_cur]);
        ones_cur = (take_first ? 1'b1 : flt_q.all_ones) && (rx_byte == '1);
        grp_cur  = take_first ? rx_byte[0] : flt_q.grp;

        if (take) begin
            flt_d.crc      = crc_nx;
            flt_d.uc_eq    = uc_cur;
            flt_d.all_ones = ones_cur;
            flt_d.grp      = grp_cur;
            if (cnt_cur == LAST_IDX) begin
                flt_d.busy      = 1'b0;
                flt_d.cnt       = '0;
                flt_d.dec_valid = 1'b1;
                flt_d.dec_idx   = idx_nx;
                if (pass_all)
                    flt_d.dec_accept = 1'b1;
                else if (ones_cur && bcast_en)
                    flt_d.dec_accept = 1'b1;
                else if (grp_cur)
                    flt_d.dec_accept = hit_nx;
                else
                    flt_d.dec_accept = uc_cur;
            end else begin
                flt_d.busy = 1'b1;
                flt_d.cnt  = cnt_cur + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign dec_valid    = flt_q.dec_valid;
    assign dec_accept   = flt_q.dec_accept;
    assign dec_hash_idx = flt_q.dec_idx;

    // R3: decision is a lone pulse and always follows a taken byte
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flt_q.dec_valid |=> !flt_q.dec_valid);
    assert_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flt_q.dec_valid |-> $past(rx_valid));

    // R2: byte position stays inside the address and rests at zero when idle
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.cnt <= LAST_IDX) && (!flt_q.busy -> flt_q.cnt == '0));

    // R9: pass-all in force at the final byte forces acceptance
    assert_pass_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.dec_valid && $past(pass_all)) |-> flt_q.dec_accept);

    // R11: decision outputs hold between pulses
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_q.dec_valid |-> ($stable(flt_q.dec_accept) && $stable(flt_q.dec_idx)));

endmodule

// File: tb/sim_mhf_addr_filter.sv
module sim_mhf_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_first = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        dec_valid, dec_accept;
    logic [5:0]  dec_hash_idx;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    mhf_addr_filter u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rx_valid(rx_valid), .rx_first(rx_first), .rx_byte(rx_byte),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_hash_idx(dec_hash_idx)
    );

    function automatic logic [31:0] crc_ref(input logic [47:0] a);
        logic [31:0] c = '1;
        for (int i = 0; i < 48; i++) begin
            if (c[31] ^ a[i]) c = {c[30:0], 1'b0} ^ 32'h04C11DB7;
            else              c = {c[30:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [5:0] idx_ref(input logic [47:0] a);
        logic [31:0] c = crc_ref(a);
        return c[31:26];
    endfunction

    task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // ends on the negedge after the last byte, where the decision is visible
    task automatic send_addr(input logic [47:0] a, input int gap);
        for (int i = 0; i < 6; i++) begin
            rx_valid = 1'b1; rx_first = (i == 0); rx_byte = a[i*8 +: 8];
            @(negedge clk);
            rx_valid = 1'b0; rx_first = 1'b0;
            if (i < 5) repeat (gap) begin
                chk(dec_valid == 1'b0, "R3 no pulse mid-address", dec_valid, 0);
                @(negedge clk);
            end
        end
    endtask

    task automatic expect_dec(input logic [47:0] a, input logic acc, input string tag);
        chk(dec_valid == 1'b1, {tag, " dec_valid pulse"}, dec_valid, 1);
        chk(dec_accept == acc, {tag, " accept"}, dec_accept, acc);
        chk(dec_hash_idx == idx_ref(a), {"R4 index for ", tag}, dec_hash_idx, idx_ref(a));
        @(negedge clk);
        chk(dec_valid == 1'b0, {"R3 pulse ends after ", tag}, dec_valid, 0);
    endtask

    task automatic clear_cfg();
        cfg_write(3'd0, 32'h0); cfg_write(3'd1, 32'h0);
        cfg_write(3'd2, 32'h0); cfg_write(3'd3, 32'h0);
        cfg_write(3'd4, 32'h0);
    endtask

    task automatic t_reset();
        chk(dec_valid == 1'b0, "R3 no decision out of reset", dec_valid, 0);
        send_addr(48'h0000_5E00_0001, 0);
        expect_dec(48'h0000_5E00_0001, 1'b0, "R6 group rejected with reset table");
        send_addr(48'h6655_4433_2210, 0);
        expect_dec(48'h6655_4433_2210, 1'b0, "R7 unicast vs zero station");
    endtask

    task automatic t_hash();
        logic [47:0] a_lo = '0, a_hi = '0;
        logic f_lo = 1'b0, f_hi = 1'b0;
        for (int b = 0; b < 256; b++) begin
            logic [47:0] a = {8'(b), 40'h00_5E00_0001};
            if (!f_lo && idx_ref(a) < 6'd32)  begin a_lo = a; f_lo = 1'b1; end
            if (!f_hi && idx_ref(a) >= 6'd32) begin a_hi = a; f_hi = 1'b1; end
        end
        clear_cfg();
        cfg_write(3'd0, 32'h1 << idx_ref(a_lo));
        send_addr(a_lo, 2);
        expect_dec(a_lo, 1'b1, "R5 low-half bit set");
        cfg_write(3'd0, ~(32'h1 << idx_ref(a_lo)));
        cfg_write(3'd1, 32'hFFFF_FFFF);
        send_addr(a_lo, 0);
        expect_dec(a_lo, 1'b0, "R5 low-half bit clear");
        cfg_write(3'd0, 32'h0);
        cfg_write(3'd1, 32'h1 << (idx_ref(a_hi) - 6'd32));
        send_addr(a_hi, 1);
        expect_dec(a_hi, 1'b1, "R5 high-half bit set");
        cfg_write(3'd1, ~(32'h1 << (idx_ref(a_hi) - 6'd32)));
        cfg_write(3'd0, 32'hFFFF_FFFF);
        send_addr(a_hi, 0);
        expect_dec(a_hi, 1'b0, "R5 high-half bit clear");
    endtask

    task automatic t_unicast();
        logic [47:0] a = 48'h6655_4433_2210;
        clear_cfg();
        cfg_write(3'd2, a[31:0]);
        cfg_write(3'd3, {16'hABCD, a[47:32]});
        send_addr(a, 0);
        expect_dec(a, 1'b1, "R7 station match");
        send_addr(a ^ (48'h1 << 44), 0);
        expect_dec(a ^ (48'h1 << 44), 1'b0, "R7 mismatch in byte 5");
        send_addr(a ^ (48'h1 << 9), 0);
        expect_dec(a ^ (48'h1 << 9), 1'b0, "R7 mismatch in byte 1");
        cfg_write(3'd5, 32'hFFFF_FFFF);
        cfg_write(3'd6, 32'hFFFF_FFFF);
        cfg_write(3'd7, 32'hFFFF_FFFF);
        send_addr(a, 0);
        expect_dec(a, 1'b1, "R1 unused codes left station intact");
        send_addr(48'h0000_5E00_0001, 0);
        expect_dec(48'h0000_5E00_0001, 1'b0, "R1 unused codes left table and flags intact");
    endtask

    task automatic t_broadcast();
        logic [47:0] bc = '1;
        clear_cfg();
        cfg_write(3'd4, 32'h1);
        send_addr(bc, 0);
        expect_dec(bc, 1'b1, "R8 broadcast enabled");
        cfg_write(3'd4, 32'h0);
        send_addr(bc, 0);
        expect_dec(bc, 1'b0, "R8 broadcast disabled empty table");
        if (idx_ref(bc) < 6'd32) cfg_write(3'd0, 32'h1 << idx_ref(bc));
        else                     cfg_write(3'd1, 32'h1 << (idx_ref(bc) - 6'd32));
        send_addr(bc, 0);
        expect_dec(bc, 1'b1, "R8 broadcast through table");
    endtask

    task automatic t_pass();
        clear_cfg();
        cfg_write(3'd4, 32'h2);
        send_addr(48'h1234_5678_9ABC, 0);
        expect_dec(48'h1234_5678_9ABC, 1'b1, "R9 pass-all unicast");
        send_addr(48'h0000_5E00_0001, 0);
        expect_dec(48'h0000_5E00_0001, 1'b1, "R9 pass-all group");
        cfg_write(3'd4, 32'h0);
    endtask

    task automatic t_trailing_restart();
        logic [47:0] a = 48'h6655_4433_2210;
        logic [47:0] b = 48'h0102_0304_0507;
        clear_cfg();
        cfg_write(3'd2, a[31:0]);
        cfg_write(3'd3, {16'h0, a[47:32]});
        send_addr(a, 0);
        expect_dec(a, 1'b1, "R7 before trailing bytes");
        for (int i = 0; i < 10; i++) begin
            rx_valid = 1'b1; rx_first = 1'b0; rx_byte = 8'(i * 17);
            @(negedge clk);
            chk(dec_valid == 1'b0, "R2 trailing byte ignored", dec_valid, 0);
        end
        rx_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(dec_accept == 1'b1, "R11 accept held", dec_accept, 1);
        chk(dec_hash_idx == idx_ref(a), "R11 index held", dec_hash_idx, idx_ref(a));
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1'b1; rx_first = (i == 0); rx_byte = 8'hFF;
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_first = 1'b0;
        send_addr(b, 0);
        expect_dec(b, 1'b0, "R10 restart on new start flag");
        send_addr(a, 0);
        expect_dec(a, 1'b1, "R10 clean address after restart");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL R3 watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hash();
        t_unicast();
        t_broadcast();
        t_pass();
        t_trailing_restart();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule